// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Early-Warning Interrupt

This block is a watchdog timer on a simple 32-bit register bus. A 32-bit down-counter runs in a slow timing domain of 32768 ticks per second. A reload value sets the start point of the count. A separate warning threshold raises an interrupt some time before expiry. When the count reaches zero, the block can raise a reset request that lasts a fixed number of slow cycles.

Every register write except the lock write is refused until a key value has been written to the lock register. Both 32-bit values are written as two 16-bit halves. Writing the low half of either value starts a toggle handshake that carries both values into the slow domain, and a busy flag stays visible until that handshake completes. Software keeps the system alive by rewriting a low half before expiry. This reloads the counter and does not stop it.

Top module: `wdg_top`

## Requirements
- R1: After reset the block is locked (lock register reads 1 in bit 0). Control, mask and status read 0, `irq` is low and `rst_req` is low.
- R2: Writing 0x0000E551 to offset 0x20 unlocks the block, and writing any other value locks it. While locked, writes to every other offset have no effect.
- R3: Each value is split into halves. The low half sits at 0x00 (reload) or 0x2C (warning) and holds bits 15:0. The high half sits at 0x04 or 0x30 and holds bits 31:16. Offsets 0x18 and 0x1C return the count halves. Every half reads back in bits 15:0, with bits 31:16 equal to zero.
- R4: The control register at 0x08 holds interrupt enable in bit 0, counter enable in bit 1, a stored mode bit in bit 2 and reset enable in bit 3. All four bits read back as written.
- R5: A write to a low half (0x00 or 0x2C) sets the busy flag (status 0x10, bit 4) in the next bus cycle. The flag clears after two to three slow cycles plus the bus-side synchroniser delay. After that, a stopped counter reads back the new reload value.
- R6: While counter enable is set, the count falls by one on each slow cycle and stops at zero. While counter enable is clear, the count stays frozen.
- R7: Status bit 0 is set when the count steps onto the warning value while interrupt enable is set. `irq` equals status bit 0 AND NOT mask bit 0 (mask register at 0x14).
- R8: Writing 1 to bit 0 of offset 0x0C clears status bit 0. Writing 1 to bit 3 of the same offset clears status bit 3.
- R9: When the count steps from 1 to 0 with reset enable set, status bit 3 is set and `rst_req` stays high for exactly 4 slow cycles. The count then holds at 0 until it is reloaded.
- R10: Rewriting the reload low half while the counter runs restarts the count from the reload value, leaves counter enable set, and prevents expiry.
- R11: If the count reaches zero while reset enable is clear, no reset request is raised and status bit 3 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| slow_clk | input | 1 | Slow counting clock, 32768 Hz |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| bus_we | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| irq | output | 1 | Early-warning interrupt, level |
| rst_req | output | 1 | System reset request, slow domain |

## Verification
Register and lock effects are due on the bus cycle after the write strobe. The bench reads them back at the next falling edge.

Results that cross clock domains have no fixed cycle count. These are the busy flag clearing, a loaded count becoming visible, the warning interrupt and a count frozen by stopping the counter. For each of these the bench derives a window in slow cycles from the requirement: the synchroniser stages plus the expected number of decrements. It then checks the measured bus-cycle delay, or the count it reads back, against that window.

The reset pulse is counted at falling edges of the slow clock and must equal exactly 4. Results that must not happen are checked after the event could have occurred: no pulse, and status bit 3 still clear.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int DATA_W      = 32;
    localparam int HALF_W      = 16;
    localparam int ADDR_W      = 6;
    localparam int PULSE_W     = 4;
    localparam int SYNC_STAGES = 2;
    localparam int PULSE_CW    = $clog2(PULSE_W + 1);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // register offsets
    localparam addr_t A_LD_LO  = 6'h00;
    localparam addr_t A_LD_HI  = 6'h04;
    localparam addr_t A_CTRL   = 6'h08;
    localparam addr_t A_CLR    = 6'h0C;
    localparam addr_t A_STAT   = 6'h10;
    localparam addr_t A_MASK   = 6'h14;
    localparam addr_t A_CNT_LO = 6'h18;
    localparam addr_t A_CNT_HI = 6'h1C;
    localparam addr_t A_LOCK   = 6'h20;
    localparam addr_t A_WRN_LO = 6'h2C;
    localparam addr_t A_WRN_HI = 6'h30;

    localparam word_t UNLOCK_KEY = 32'h0000_E551;

    // status and clear bit positions
    localparam int B_WARN = 0;
    localparam int B_EXP  = 3;
    localparam int B_BUSY = 4;

    typedef struct packed {
        logic rst_en;
        logic mode;
        logic cnt_en;
        logic int_en;
    } ctrl_t;

    // slow-domain control bits actually used by the counter
    typedef struct packed {
        logic rst_en;
        logic cnt_en;
        logic int_en;
    } run_t;

    function automatic half_t upper_half(word_t w);
        return w[DATA_W-1:HALF_W];
    endfunction

    function automatic half_t lower_half(word_t w);
        return w[HALF_W-1:0];
    endfunction

    function automatic word_t half_rd(half_t h);
        return {{(DATA_W-HALF_W){1'b0}}, h};
    endfunction

endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wdg_bus_regs.sv
module wdg_bus_regs
    import wdg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bus_we,
    input  addr_t bus_addr,
    input  word_t bus_wdata,
    output word_t bus_rdata,
    output logic  irq,
    output word_t ld_val,
    output word_t wrn_val,
    output logic  ld_req_tgl,
    output ctrl_t ctrl_q,
    input  logic  ld_ack_s,
    input  logic  pub_s,
    input  logic  warn_s,
    input  logic  exp_s,
    input  word_t cnt_pub
);
    localparam int NEV = 3;

    logic         locked;
    logic         mask_q;
    logic         st_warn, st_exp;
    logic         pend;
    word_t        cnt_cap;
    logic [NEV-1:0] ev_s, ev_d, ev_edge;

    logic wr_ok, lo_wr, busy_core, busy;
    logic clr_warn, clr_exp;

    assign ev_s = {exp_s, warn_s, pub_s};

    // edge detect on each toggle that arrives from the slow domain
    for (genvar i = 0; i < NEV; i++) begin : g_edge
        assign ev_edge[i] = ev_s[i] ^ ev_d[i];
    end

    assign wr_ok     = bus_we && !locked;
    assign lo_wr     = wr_ok && (bus_addr == A_LD_LO || bus_addr == A_WRN_LO);
    assign busy_core = ld_req_tgl ^ ld_ack_s;
    assign busy      = busy_core | pend;
    assign clr_warn  = wr_ok && bus_addr == A_CLR && bus_wdata[B_WARN];
    assign clr_exp   = wr_ok && bus_addr == A_CLR && bus_wdata[B_EXP];

    always_ff @(posedge clk) begin
        if (rst) begin
            locked     <= 1'b1;
            mask_q     <= 1'b0;
            ctrl_q     <= '0;
            ld_val     <= '0;
            wrn_val    <= '0;
            ld_req_tgl <= 1'b0;
            pend       <= 1'b0;
            st_warn    <= 1'b0;
            st_exp     <= 1'b0;
            cnt_cap    <= '0;
            ev_d       <= '0;
        end else begin
            ev_d <= ev_s;
            if (bus_we && bus_addr == A_LOCK)
                locked <= (bus_wdata != UNLOCK_KEY);
            if (wr_ok) begin
                unique case (bus_addr)
                    A_LD_LO:  ld_val[HALF_W-1:0]       <= lower_half(bus_wdata);
                    A_LD_HI:  ld_val[DATA_W-1:HALF_W]  <= lower_half(bus_wdata);
                    A_WRN_LO: wrn_val[HALF_W-1:0]      <= lower_half(bus_wdata);
                    A_WRN_HI: wrn_val[DATA_W-1:HALF_W] <= lower_half(bus_wdata);
                    A_CTRL:   ctrl_q                   <= ctrl_t'(bus_wdata[3:0]);
                    A_MASK:   mask_q                   <= bus_wdata[0];
                    default: ;
                endcase
            end
            // a new request is only launched once the previous one is acknowledged
            if (lo_wr || pend) begin
                if (busy_core) begin
                    pend <= 1'b1;
                end else begin
                    ld_req_tgl <= ~ld_req_tgl;
                    pend       <= 1'b0;
                end
            end
            if (ev_edge[0]) cnt_cap <= cnt_pub;
            // a new event wins over a clear in the same cycle
            if (ev_edge[1])    st_warn <= 1'b1;
            else if (clr_warn) st_warn <= 1'b0;
            if (ev_edge[2])    st_exp <= 1'b1;
            else if (clr_exp)  st_exp <= 1'b0;
        end
    end

    assign irq = st_warn & ~mask_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_LD_LO:  bus_rdata = half_rd(lower_half(ld_val));
            A_LD_HI:  bus_rdata = half_rd(upper_half(ld_val));
            A_WRN_LO: bus_rdata = half_rd(lower_half(wrn_val));
            A_WRN_HI: bus_rdata = half_rd(upper_half(wrn_val));
            A_CNT_LO: bus_rdata = half_rd(lower_half(cnt_cap));
            A_CNT_HI: bus_rdata = half_rd(upper_half(cnt_cap));
            A_CTRL:   bus_rdata[3:0] = ctrl_q;
            A_MASK:   bus_rdata[0]   = mask_q;
            A_LOCK:   bus_rdata[0]   = locked;
            A_STAT: begin
                bus_rdata[B_WARN] = st_warn;
                bus_rdata[B_EXP]  = st_exp;
                bus_rdata[B_BUSY] = busy;
            end
            default: bus_rdata = '0;
        endcase
    end

    // R2: a refused control write leaves control untouched
    p_locked_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && locked && bus_addr == A_CTRL) |=> $stable(ctrl_q));

    // R5: a low-half write is visible as busy in the next cycle
    p_busy_after_load_r5: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> busy);

    // R8: a clear without a coincident event empties the warning bit
    p_clear_warn_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_warn && !ev_edge[1]) |=> !st_warn);
endmodule

// File: rtl/wdg_slow_core.sv
module wdg_slow_core
    import wdg_pkg::*;
(
    input  logic  slow_clk,
    input  logic  slow_rst,
    input  logic  ld_req_s,
    input  word_t ld_val,
    input  word_t wrn_val,
    input  run_t  run_s,
    output logic  ld_ack_tgl,
    output logic  pub_tgl,
    output word_t cnt_pub,
    output logic  warn_tgl,
    output logic  exp_tgl,
    output logic  rst_req
);
    word_t               cnt, wrn_q, cnt_dec;
    logic                req_d;
    logic [PULSE_CW-1:0] pulse_cnt;
    logic                load_evt, stepping, fire;

    assign load_evt = ld_req_s ^ req_d;
    assign stepping = !load_evt && run_s.cnt_en && (cnt != '0);
    assign cnt_dec  = cnt - 1'b1;
    assign fire     = stepping && run_s.rst_en && (cnt_dec == '0);

    always_ff @(posedge slow_clk) begin
        if (slow_rst) begin
            cnt        <= '0;
            wrn_q      <= '0;
            req_d      <= 1'b0;
            ld_ack_tgl <= 1'b0;
            pub_tgl    <= 1'b0;
            cnt_pub    <= '0;
            warn_tgl   <= 1'b0;
            exp_tgl    <= 1'b0;
            rst_req    <= 1'b0;
            pulse_cnt  <= '0;
        end else begin
            req_d   <= ld_req_s;
            pub_tgl <= ~pub_tgl;
            cnt_pub <= cnt;
            if (load_evt) begin
                cnt        <= ld_val;
                wrn_q      <= wrn_val;
                ld_ack_tgl <= ld_req_s;
            end else if (stepping) begin
                cnt <= cnt_dec;
                if (run_s.int_en && cnt_dec == wrn_q)
                    warn_tgl <= ~warn_tgl;
            end
            if (fire) begin
                exp_tgl   <= ~exp_tgl;
                rst_req   <= 1'b1;
                pulse_cnt <= PULSE_CW'(PULSE_W - 1);
            end else if (pulse_cnt != '0) begin
                pulse_cnt <= pulse_cnt - 1'b1;
            end else begin
                rst_req <= 1'b0;
            end
        end
    end

    // R6: a running counter steps down by exactly one
    p_decrement_r6: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (!load_evt && run_s.cnt_en && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

    // R9: an expired counter stays at zero until a reload
    p_hold_zero_r9: assert property (@(posedge slow_clk) disable iff (slow_rst)
        (cnt == '0 && !load_evt) |=> cnt == '0);

    // R9: the reset request is never a single-cycle glitch
    p_pulse_min_r9: assert property (@(posedge slow_clk) disable iff (slow_rst)
        $rose(rst_req) |=> rst_req);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_clk,
    input  logic              slow_rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    word_t ld_val, wrn_val, cnt_pub;
    ctrl_t ctrl_q;
    run_t  run_b, run_s;
    logic  ld_req_tgl, ld_req_s;
    logic  ld_ack_tgl, pub_tgl, warn_tgl, exp_tgl;
    logic  ld_ack_s, pub_s, warn_s, exp_s;

    assign run_b = '{rst_en: ctrl_q.rst_en, cnt_en: ctrl_q.cnt_en, int_en: ctrl_q.int_en};

    wdg_bus_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .ld_val    (ld_val),
        .wrn_val   (wrn_val),
        .ld_req_tgl(ld_req_tgl),
        .ctrl_q    (ctrl_q),
        .ld_ack_s  (ld_ack_s),
        .pub_s     (pub_s),
        .warn_s    (warn_s),
        .exp_s     (exp_s),
        .cnt_pub   (cnt_pub)
    );

    wdg_sync #(.W(1 + $bits(run_t)), .STAGES(SYNC_STAGES)) u_to_slow (
        .clk(slow_clk),
        .rst(slow_rst),
        .d  ({ld_req_tgl, run_b}),
        .q  ({ld_req_s, run_s})
    );

    wdg_sync #(.W(4), .STAGES(SYNC_STAGES)) u_to_bus (
        .clk(clk),
        .rst(rst),
        .d  ({ld_ack_tgl, pub_tgl, warn_tgl, exp_tgl}),
        .q  ({ld_ack_s, pub_s, warn_s, exp_s})
    );

    wdg_slow_core u_core (
        .slow_clk  (slow_clk),
        .slow_rst  (slow_rst),
        .ld_req_s  (ld_req_s),
        .ld_val    (ld_val),
        .wrn_val   (wrn_val),
        .run_s     (run_s),
        .ld_ack_tgl(ld_ack_tgl),
        .pub_tgl   (pub_tgl),
        .cnt_pub   (cnt_pub),
        .warn_tgl  (warn_tgl),
        .exp_tgl   (exp_tgl),
        .rst_req   (rst_req)
    );
endmodule

// File: tb/tb_wdg_top.sv
`timescale 1ns/1ps
module tb_wdg_top;
    localparam int SLOW_DIV = 10;

    logic        clk = 1'b0, slow_clk = 1'b0;
    logic        rst = 1'b1, slow_rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;

    int total = 0, bad = 0;
    int pulse_hi = 0;
    logic [31:0] rv;
    bit done = 0;

    always #4 clk = ~clk;
    initial begin
        #3;
        forever #(SLOW_DIV * 4) slow_clk = ~slow_clk;
    end

    wdg_top dut (
        .clk(clk), .rst(rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    always @(negedge slow_clk) if (rst_req) pulse_hi++;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_rng(string req, int act, int lo, int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    // expected count after n decrements from a start value, stopping at zero
    function automatic int after_steps(int start, int n);
        return (start > n) ? start - n : 0;
    endfunction

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_slow(int n);
        repeat (n) @(posedge slow_clk);
        @(negedge clk);
    endtask

    // wait for busy to clear; returns bus cycles spent
    task automatic wait_idle(output int cyc);
        logic [31:0] s;
        cyc = 0;
        do begin
            rd(6'h10, s);
            cyc++;
        end while (s[4] && cyc < 200);
    endtask

    task automatic load(logic [5:0] lo_addr, logic [31:0] v);
        int c;
        wr(lo_addr + 6'h04, {16'h0, v[31:16]});
        wr(lo_addr, {16'h0, v[15:0]});
        wait_idle(c);
    endtask

    task automatic read_cnt(output logic [31:0] v);
        logic [31:0] h, l;
        rd(6'h1C, h);
        rd(6'h18, l);
        v = {h[15:0], l[15:0]};
    endtask

    initial begin
        int cyc;
        logic [31:0] c1, c2;
        void'($urandom(32'd2024));
        repeat (30) @(negedge clk);
        rst = 1'b0; slow_rst = 1'b0;

        // R1 reset state
        rd(6'h20, rv); check("R1 lock", rv, 32'h1);
        rd(6'h08, rv); check("R1 ctrl", rv, 32'h0);
        rd(6'h10, rv); check("R1 status", rv, 32'h0);
        rd(6'h14, rv); check("R1 mask", rv, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 rst_req", {31'h0, rst_req}, 32'h0);

        // R2 lock gating
        wr(6'h08, 32'hF);
        rd(6'h08, rv); check("R2 locked write ignored", rv, 32'h0);
        wr(6'h20, 32'h0000E551);
        rd(6'h20, rv); check("R2 unlocked", rv, 32'h0);
        wr(6'h08, 32'h4);
        rd(6'h08, rv); check("R4 mode bit readback", rv, 32'h4);
        for (int i = 0; i < 8; i++) begin
            logic [31:0] key;
            key = $urandom();
            if (key == 32'h0000E551) key = 32'h0;
            wr(6'h20, key);
            rd(6'h20, rv); check("R2 other key locks", rv, 32'h1);
            wr(6'h08, 32'h0);
            wr(6'h14, 32'h1);
            rd(6'h08, rv); check("R2 ctrl unchanged", rv, 32'h4);
            rd(6'h14, rv); check("R2 mask unchanged", rv, 32'h0);
            wr(6'h20, 32'h0000E551);
        end
        wr(6'h08, 32'hD);
        rd(6'h08, rv); check("R4 ctrl readback", rv, 32'hD);
        wr(6'h08, 32'h0);

        // R5 busy handshake, R3 halves
        wr(6'h04, 32'hABCD_0003);
        wr(6'h00, 32'h1234_0005);
        rd(6'h10, rv); check("R5 busy set", {31'h0, rv[4]}, 32'h1);
        wait_idle(cyc);
        check_rng("R5 busy duration", cyc, 12, 45);
        wait_slow(3);
        rd(6'h1C, rv); check("R3 count high", rv, 32'h3);
        rd(6'h18, rv); check("R3 count low", rv, 32'h5);
        rd(6'h04, rv); check("R3 load high readback", rv, 32'h3);
        wr(6'h30, 32'hFFFF_0007);
        rd(6'h30, rv); check("R3 warn high readback", rv, 32'h7);
        for (int i = 0; i < 6; i++) begin
            logic [31:0] v;
            v = $urandom();
            load(6'h00, v);
            wait_slow(3);
            read_cnt(rv); check("R5 stopped count equals load", rv, v);
        end

        // R6 counting and freezing
        load(6'h2C, 32'd0);
        load(6'h00, 32'd1000);
        wr(6'h08, 32'h2);
        wait_slow(20);
        wr(6'h08, 32'h0);
        wait_slow(5);
        read_cnt(c1);
        check_rng("R6 decrement rate", int'(c1), after_steps(1000, 22), after_steps(1000, 18));
        wait_slow(10);
        read_cnt(c2); check("R6 frozen when off", c2, c1);

        // R7 warning interrupt, mask, R8 clear, R11 no reset
        load(6'h2C, 32'd10);
        load(6'h00, 32'd30);
        pulse_hi = 0;
        wr(6'h08, 32'h3);
        cyc = 0;
        while (!irq && cyc < 600) begin @(negedge clk); cyc++; end
        check_rng("R7 warning delay", cyc, (30 - 10 + 1) * SLOW_DIV, (30 - 10 + 5) * SLOW_DIV);
        rd(6'h10, rv); check("R7 status warn", {31'h0, rv[0]}, 32'h1);
        wr(6'h14, 32'h1);
        @(negedge clk);
        check("R7 masked irq", {31'h0, irq}, 32'h0);
        rd(6'h10, rv); check("R7 status kept under mask", {31'h0, rv[0]}, 32'h1);
        wr(6'h0C, 32'h1);
        rd(6'h10, rv); check("R8 warn cleared", {31'h0, rv[0]}, 32'h0);
        wr(6'h14, 32'h0);
        @(negedge clk);
        check("R8 irq low after clear", {31'h0, irq}, 32'h0);
        wait_slow(20);
        read_cnt(rv); check("R11 count at zero", rv, 32'h0);
        rd(6'h10, rv); check("R11 no expiry status", {31'h0, rv[3]}, 32'h0);
        check("R11 no reset pulse", pulse_hi, 32'h0);

        // R9 expiry with reset
        wr(6'h08, 32'h0);
        load(6'h00, 32'd12);
        pulse_hi = 0;
        wr(6'h08, 32'hA);
        wait_slow(30);
        check("R9 pulse width", pulse_hi, 32'd4);
        rd(6'h10, rv); check("R9 expiry status", {31'h0, rv[3]}, 32'h1);
        wait_slow(10);
        read_cnt(rv); check("R9 holds at zero", rv, 32'h0);
        check("R9 rst_req low after pulse", {31'h0, rst_req}, 32'h0);
        wr(6'h0C, 32'h8);
        rd(6'h10, rv); check("R8 expiry cleared", {31'h0, rv[3]}, 32'h0);

        // R10 keep-alive
        wr(6'h08, 32'h0);
        load(6'h00, 32'd40);
        pulse_hi = 0;
        wr(6'h08, 32'hA);
        for (int i = 0; i < 5; i++) begin
            wait_slow(25);
            wr(6'h00, 32'd40);
            wait_idle(cyc);
            wait_slow(3);
            read_cnt(rv);
            check_rng("R10 reload restarts count", int'(rv), 34, 40);
        end
        rd(6'h08, rv); check("R10 counter still enabled", rv, 32'hA);
        check("R10 no reset while fed", pulse_hi, 32'h0);
        rd(6'h10, rv); check("R10 no expiry status", {31'h0, rv[3]}, 32'h0);
        wait_slow(60);
        check("R10 expiry once feeding stops", pulse_hi, 32'd4);

        done = 1;
    end

    initial begin
        int n = 0;
        while (!done && n < 100000) begin @(posedge clk); n++; end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule